// File: doc/BRIEF.md
# Oversampled serial receiver with break flag

This block recovers characters from one asynchronous serial line that is sampled on a clock enable running at sixteen times the bit rate. A character is a low start bit, 8 data bits (or 9 when the wide mode input is high) sent least significant bit first, and one stop bit. The block qualifies the start bit by a majority vote. It votes each data and stop bit over three slots in the middle of the bit. It keeps a receive-full flag, a framing-error flag, a break flag and a busy flag for a host that reads a status register and a data register.

A frame in which every sampled bit is low, the stop position included, is a break. A break sets the break, framing-error and full flags together. The host clears the flags with one sequence: a status read strobe, then a data read strobe. Only the flags that were set at the status read are cleared. The busy flag rises on the first low sample of the start-bit search. It drops when the start bit fails its vote, or when a whole frame time of continuous ones follows a completed character. A new start is recognised only after the line has been seen high. For this reason a break that continues without interruption produces no further characters and cannot raise the break flag again.

Top module: `uart_brk_rx`

## Requirements
- R1: A frame with start, all data bits and the stop slot sampled low sets break_o, frame_err_o and full_o in the same cycle.
- R2: In 9-bit mode (nine_bit_i=1) bit8_o carries the ninth received bit; after a break, bit8_o is 0.
- R3: A data_rd_i strobe clears break_o, full_o and frame_err_o only if a stat_rd_i strobe came first with the flag set. A data_rd_i strobe with no status read before it leaves the flags unchanged. When a flag is set and cleared in the same cycle, the set wins.
- R4: Once break_o has been cleared, it stays 0 while the line stays low. It is set again only after the line has been sampled high and a new break frame has then been received.
- R5: busy_o rises one tick after the synchronised line is first sampled low (slot 1) while the receiver is searching for a start bit.
- R6: When the majority of slots 3, 5 and 7 of the start bit reads high, the start is false: busy_o falls and no character is delivered.
- R7: busy_o stays high after a completed character. It falls after (data bits + 2) × 16 consecutive high ticks that follow the character.
- R8: data_o holds the 8 received data bits, first received bit at bit 0. It changes only when a character completes, and reset does not alter it.
- R9: A character with a high stop bit sets full_o and clears frame_err_o. A character that has a low stop bit and at least one high data bit sets full_o and frame_err_o but not break_o.
- R10: Reset clears full_o, frame_err_o, break_o and busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable at 16x the bit rate |
| rx_i | input | 1 | Serial line, idle high |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| stat_rd_i | input | 1 | Single-cycle status register read strobe |
| data_rd_i | input | 1 | Single-cycle data register read strobe |
| data_o | output | 8 | Received data bits |
| bit8_o | output | 1 | Ninth received bit (9-bit mode) |
| full_o | output | 1 | Received character waiting |
| frame_err_o | output | 1 | Stop bit sampled low |
| break_o | output | 1 | Break character received |
| busy_o | output | 1 | Reception in progress |

## Verification
The completion of a break character and the data read that ends a clear sequence can fall in the same cycle. If they do, the flag set by the new break must survive the clear. The bench arms a clear with a status read and sends a second break. It moves the data read strobe one cycle at a time across the whole stop bit. From the frame timing it expects break_o and full_o to stay set for every read at or before the completion cycle, and to be clear for every later read.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_brk_sync.sv
module uart_brk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/uart_brk_frame.sv
module uart_brk_frame
  import uart_brk_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              nine_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              b8_o,
  output logic              stop_o,
  output logic              zero_o,
  output logic              busy_o
);
  localparam int CW     = $clog2(OSR);
  localparam int BW     = $clog2(DATA_W + 1);
  localparam int IDLE8  = (DATA_W + 2) * OSR;
  localparam int IDLE9  = (DATA_W + 3) * OSR;
  localparam int IW     = $clog2(IDLE9 + 1);
  localparam int MID    = OSR / 2;
  localparam logic [CW-1:0] SL3  = CW'(2);
  localparam logic [CW-1:0] SL5  = CW'(4);
  localparam logic [CW-1:0] SL7  = CW'(6);
  localparam logic [CW-1:0] VA   = CW'(MID - 1);
  localparam logic [CW-1:0] VB   = CW'(MID);
  localparam logic [CW-1:0] VC   = CW'(MID + 1);
  localparam logic [CW-1:0] WRAP = '0;

  rx_state_e       state;
  logic [CW-1:0]   rt, rt_n;
  logic [BW-1:0]   bidx, blast;
  logic [DATA_W:0] sh;
  logic            v_a, v_b, vote;
  logic            any_one, line_hi, busy, idle_en, done, stop;
  logic [IW-1:0]   idle_cnt, idle_lim;

  assign rt_n     = rt + 1'b1;
  assign vote     = maj3(v_a, v_b, rx_i);
  assign blast    = nine_i ? BW'(DATA_W) : BW'(DATA_W - 1);
  assign idle_lim = nine_i ? IW'(IDLE9 - 1) : IW'(IDLE8 - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      rt       <= '0;
      bidx     <= '0;
      sh       <= '0;
      v_a      <= 1'b1;
      v_b      <= 1'b1;
      any_one  <= 1'b0;
      line_hi  <= 1'b0;
      busy     <= 1'b0;
      idle_en  <= 1'b0;
      idle_cnt <= '0;
      done     <= 1'b0;
      stop     <= 1'b1;
    end else begin
      done <= 1'b0;
      if (tick_i) begin
        unique case (state)
          ST_IDLE: begin
            if (rx_i) line_hi <= 1'b1;
            if (line_hi && !rx_i) begin
              state    <= ST_START;
              rt       <= '0;
              busy     <= 1'b1;
              idle_en  <= 1'b0;
              idle_cnt <= '0;
              any_one  <= 1'b0;
              sh       <= '0;
            end else if (idle_en) begin
              if (!rx_i) idle_cnt <= '0;
              else if (idle_cnt == idle_lim) begin
                busy    <= 1'b0;
                idle_en <= 1'b0;
              end else idle_cnt <= idle_cnt + 1'b1;
            end
          end
          ST_START: begin
            rt <= rt_n;
            if (rt_n == SL3) v_a <= rx_i;
            if (rt_n == SL5) v_b <= rx_i;
            if (rt_n == SL7 && vote) begin
              state <= ST_IDLE;   // false start
              busy  <= 1'b0;
            end else if (rt_n == WRAP) begin
              state <= ST_DATA;
              bidx  <= '0;
            end
          end
          ST_DATA: begin
            rt <= rt_n;
            if (rt_n == VA) v_a <= rx_i;
            if (rt_n == VB) v_b <= rx_i;
            if (rt_n == VC) begin
              sh      <= {vote, sh[DATA_W:1]};
              any_one <= any_one | vote;
            end
            if (rt_n == WRAP) begin
              if (bidx == blast) state <= ST_STOP;
              else               bidx  <= bidx + 1'b1;
            end
          end
          ST_STOP: begin
            rt <= rt_n;
            if (rt_n == VA) v_a <= rx_i;
            if (rt_n == VB) v_b <= rx_i;
            if (rt_n == VC) begin
              done     <= 1'b1;
              stop     <= vote;
              state    <= ST_IDLE;
              line_hi  <= 1'b0;
              idle_en  <= 1'b1;
              idle_cnt <= '0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o = done;
  assign data_o = nine_i ? sh[DATA_W-1:0] : sh[DATA_W:1];
  assign b8_o   = nine_i & sh[DATA_W];
  assign stop_o = stop;
  assign zero_o = ~any_one;
  assign busy_o = busy;

  AST_BUSY_RT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(tick_i && !rx_i && state == ST_IDLE)); // R5
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> $past(state == ST_START || (state == ST_IDLE && idle_en))); // R6
  AST_NO_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> state != ST_START); // R4
endmodule

// File: rtl/uart_brk_flags.sv
module uart_brk_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic              b8_i,
  input  logic              stop_i,
  input  logic              zero_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              b8_o,
  output logic              full_o,
  output logic              fe_o,
  output logic              brk_o
);
  logic [DATA_W-1:0] data_q;
  logic b8_q, full, fe, brk, arm, rd_armed, sn_full, sn_fe, sn_brk;
  logic is_brk, clr;

  assign is_brk = done_i & zero_i & ~stop_i;
  assign clr    = data_rd_i & rd_armed;

  // data holding register has no reset
  always_ff @(posedge clk_i) begin
    if (done_i) begin
      data_q <= char_i;
      b8_q   <= is_brk ? 1'b0 : b8_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full     <= 1'b0;
      fe       <= 1'b0;
      brk      <= 1'b0;
      arm      <= 1'b1;
      rd_armed <= 1'b0;
      sn_full  <= 1'b0;
      sn_fe    <= 1'b0;
      sn_brk   <= 1'b0;
    end else begin
      if (stat_rd_i) begin
        rd_armed <= 1'b1;
        sn_full  <= full;
        sn_fe    <= fe;
        sn_brk   <= brk;
      end else if (data_rd_i) begin
        rd_armed <= 1'b0;
      end
      // set has priority over clear
      if (done_i)             full <= 1'b1;
      else if (clr && sn_full) full <= 1'b0;
      if (done_i)             fe <= ~stop_i;
      else if (clr && sn_fe)  fe <= 1'b0;
      if (is_brk && arm)      brk <= 1'b1;
      else if (clr && sn_brk) brk <= 1'b0;
      if (is_brk)             arm <= 1'b0;
      else if (tick_i && rx_i) arm <= 1'b1;
    end
  end

  assign data_o = data_q;
  assign b8_o   = b8_q;
  assign full_o = full;
  assign fe_o   = fe;
  assign brk_o  = brk;

  AST_BRK_WITH_FE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk) |-> (fe && full)); // R1
  AST_BRK_B8_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk) |-> !b8_q); // R2
  AST_BRK_CLR_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brk) |-> $past(data_rd_i && rd_armed && sn_brk)); // R3
  AST_BRK_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk) |-> $past(arm)); // R4
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(data_q)); // R8
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              nine_bit_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit8_o,
  output logic              full_o,
  output logic              frame_err_o,
  output logic              break_o,
  output logic              busy_o
);
  logic              rx_s, done, b8, stop, zero;
  logic [DATA_W-1:0] chr;

  uart_brk_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  uart_brk_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rx_i(rx_s),
    .nine_i(nine_bit_i), .done_o(done), .data_o(chr), .b8_o(b8),
    .stop_o(stop), .zero_o(zero), .busy_o(busy_o)
  );

  uart_brk_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rx_i(rx_s),
    .done_i(done), .char_i(chr), .b8_i(b8), .stop_i(stop), .zero_i(zero),
    .stat_rd_i(stat_rd_i), .data_rd_i(data_rd_i), .data_o(data_o),
    .b8_o(bit8_o), .full_o(full_o), .fe_o(frame_err_o), .brk_o(break_o)
  );
endmodule

// File: tb/uart_brk_rx_tb.sv
module uart_brk_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic rx = 1'b1;
  logic nine = 1'b0;
  logic stat_rd = 1'b0;
  logic data_rd = 1'b0;
  logic [7:0] data;
  logic bit8, full, fe, brk, busy;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // stop-bit cycle in which a character completes (derived from slot timing)
  localparam int DONE_C = 12;

  always #2.5 clk = ~clk;

  uart_brk_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx),
    .nine_bit_i(nine), .stat_rd_i(stat_rd), .data_rd_i(data_rd),
    .data_o(data), .bit8_o(bit8), .full_o(full), .frame_err_o(fe),
    .break_o(brk), .busy_o(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] d, input bit nb9, input bit stp, input int rd_at);
    rx = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < (nb9 ? 9 : 8); i++) begin
      rx = d[i];
      repeat (16) @(negedge clk);
    end
    rx = stp;
    for (int c = 0; c < 16; c++) begin
      data_rd = (c == rd_at);
      @(negedge clk);
    end
    data_rd = 1'b0;
    rx = 1'b1;
  endtask

  task automatic rd_stat();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic rd_data();
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic hold(input logic lvl, input int n);
    rx = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 full", full, 0);
    chk("R10 fe", fe, 0);
    chk("R10 brk", brk, 0);
    chk("R10 busy", busy, 0);
    rst_n = 1'b1;
    hold(1'b1, 20);

    // R8 R9 R3: 8-bit sweep
    for (int v = 0; v < 256; v++) begin
      send(9'(v), 1'b0, 1'b1, -1);
      chk("R8 data", data, 32'(v));
      chk("R9 full", full, 1);
      chk("R9 fe", fe, 0);
      rd_stat(); rd_data();
      chk("R3 full clr", full, 0);
    end

    // R2: 9-bit sweep
    nine = 1'b1;
    for (int i = 0; i < 31; i++) begin
      send(9'(i * 17), 1'b1, 1'b1, -1);
      chk("R2 data", data, 32'((i * 17) & 255));
      chk("R2 bit8", bit8, 32'((i * 17) >> 8));
      rd_stat(); rd_data();
    end
    nine = 1'b0;

    // R7: busy holds after char, drops after idle frame
    send(9'h3c, 1'b0, 1'b1, -1);
    chk("R7 busy after char", busy, 1);
    hold(1'b1, 140);
    chk("R7 busy before idle", busy, 1);
    hold(1'b1, 30);
    chk("R7 busy after idle", busy, 0);
    rd_stat(); rd_data();

    // R5 R6: first low sample, then false start
    rx = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 busy at rt1", busy, 1);
    hold(1'b1, 30);
    chk("R6 busy false", busy, 0);
    chk("R6 no char", full, 0);

    // R9: low stop, nonzero data
    send(9'h55, 1'b0, 1'b0, -1);
    chk("R9 fe", fe, 1);
    chk("R9 full", full, 1);
    chk("R9 no brk", brk, 0);
    rd_stat(); rd_data();
    chk("R3 fe clr", fe, 0);
    hold(1'b1, 20);

    // R1 R2: break after a 9-bit char with ninth bit high
    nine = 1'b1;
    send(9'h1a5, 1'b1, 1'b1, -1);
    chk("R2 bit8 set", bit8, 1);
    hold(1'b1, 20);
    send(9'h000, 1'b1, 1'b0, -1);
    chk("R1 brk", brk, 1);
    chk("R1 fe", fe, 1);
    chk("R1 full", full, 1);
    chk("R2 bit8 brk", bit8, 0);
    chk("R8 data brk", data, 0);
    nine = 1'b0;
    hold(1'b1, 20);

    // R3: data read alone keeps flags
    rd_data();
    chk("R3 data only brk", brk, 1);
    chk("R3 data only full", full, 1);
    rd_stat(); rd_data();
    chk("R3 brk clr", brk, 0);
    chk("R3 full clr2", full, 0);
    hold(1'b1, 20);

    // R4: no re-set while line stays low
    send(9'h000, 1'b0, 1'b0, -1);
    chk("R4 first brk", brk, 1);
    rx = 1'b0;
    rd_stat(); rd_data();
    chk("R4 cleared", brk, 0);
    hold(1'b0, 400);
    chk("R4 stays clear", brk, 0);
    chk("R4 no char", full, 0);
    hold(1'b1, 32);
    send(9'h000, 1'b0, 1'b0, -1);
    chk("R4 rearmed", brk, 1);
    rd_stat(); rd_data();
    hold(1'b1, 20);

    // R1 R3: sweep clearing read across the stop bit of a new break
    for (int k = 0; k < 16; k++) begin
      send(9'h000, 1'b0, 1'b0, -1);
      hold(1'b1, 20);
      rd_stat();
      hold(1'b1, 20);
      send(9'h000, 1'b0, 1'b0, k);
      chk("R3 collide brk", brk, (k <= DONE_C) ? 1 : 0);
      chk("R1 collide full", full, (k <= DONE_C) ? 1 : 0);
      rd_stat(); rd_data();
      hold(1'b1, 20);
    end

    // R8 R10: reset leaves data, clears flags
    send(9'h0a5, 1'b0, 1'b1, -1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 data kept", data, 32'ha5);
    chk("R10 full rst", full, 0);
    chk("R10 brk rst", brk, 0);
    chk("R10 busy rst", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule